// File: doc/BRIEF.md
# Boundary-Scan Flash Write Sequencer

This block is a compact test access port. It pairs a boundary-scan style data register with a flash write helper. The parallel side of the register drives the address bus, data bus, chip enable and active-low write enable of an external parallel flash. The flash has no test logic of its own, so every value it sees passes through this register. The register holds only the bits the flash needs, which keeps each scan short.

The host can write to the flash in two ways. In the plain method it scans the same address and data three times, with the write-enable bit high, then low, then high again. In the auto-write method, the `aw_en` pin is held high. One scan then carries address and data, and the block produces the write-enable pulse by itself after the update. A flash write then costs one scan instead of three.

Top module: `bsf_write_seq`

## Requirements
- R1: The controller follows the sixteen-state test access port state machine on rising `tck`. A low `trst_n` at a rising edge, or five consecutive rising edges with `tms` high, brings it to Test-Logic-Reset. That state restores BYPASS in the instruction register and the safe value in the flash latch.
- R2: The instruction register is 4 bits wide and shifts in least significant bit first. Its capture value is 0001. Code 0000 selects flash drive mode (EXTEST). Code 0001 selects SAMPLE. Code 1111 selects BYPASS, and every other code also behaves as BYPASS. BYPASS is a 1-bit stage that captures 0, so data shifted through it comes out one `tck` late.
- R3: Under EXTEST or SAMPLE, the data path is a 42-bit register. Bit 0, nearest `tdo`, is address bit 0. Bits 23:0 are the address, bits 39:24 the data, bit 40 the chip-enable bit and bit 41 the write-enable bit, the bit nearest `tdi`. In Capture-DR it loads the current latch contents, so the next scan reads back what is being driven.
- R4: The flash pins follow the latch only while EXTEST is the current instruction. Under any other instruction they rest at write enable 1, chip enable 1, address 0 and data 0.
- R5: The latch takes the scanned value on the falling `tck` edge in Update-DR. With `aw_en` low, the write-enable pin follows the scanned write-enable bit. This is the three-scan plain method.
- R6: With `aw_en` high, the latch stores a 1 for write enable whatever was scanned. An Update-DR under EXTEST then starts a pulse, counted from the rising edge that leaves Update-DR: 1 `tck` of setup with write enable high, 2 `tck` with write enable low, and 1 `tck` of hold with write enable high.
- R7: An Update-DR that arrives while a pulse is in progress changes neither the latch nor the pulse. It sets `aw_overrun`, which stays high until `trst_n` is low.
- R8: `tdo` changes only on falling `tck`. It is 0 in every state other than Shift-IR and Shift-DR.
- R9: Address and data on the flash pins stay stable while an auto-write pulse holds write enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, sampled on rising tck |
| tms | input | 1 | Mode select |
| tdi | input | 1 | Serial data in |
| aw_en | input | 1 | Selects the auto-write method |
| tdo | output | 1 | Serial data out, updated on falling tck |
| flash_addr | output | 24 | Flash address bus |
| flash_data | output | 16 | Flash data bus |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_we_n | output | 1 | Flash write enable, active low |
| aw_overrun | output | 1 | Sticky flag: an update arrived during a pulse |

## Verification
The hardest case to reach is an Update-DR that lands inside a running auto-write pulse. Any full 42-bit scan takes far longer than the four-cycle pulse. The bench therefore finishes a scan in Update-DR and leaves it at once. It takes the shortest loop back, through Select-DR, Capture-DR and Exit1-DR, and lands on Update-DR during the hold cycle. The capture reloads the register with the latch contents, so the ignored update is seen at the pins as the missing second write-enable pulse, and as the overrun flag rising.

// File: rtl/bsf_pkg.sv
package bsf_pkg;

    localparam int IR_W = 4;

    typedef enum logic [3:0] {
        TLR, RTI, SEL_DR, CAP_DR, SHF_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
        SEL_IR, CAP_IR, SHF_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
    } tap_state_t;

    localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0001;
    localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

    typedef enum logic [1:0] {AW_IDLE, AW_SETUP, AW_LOW, AW_HOLD} aw_phase_t;

    typedef struct packed {
        logic extest;
        logic bsr_sel;
    } ir_dec_t;

    function automatic tap_state_t tap_next(tap_state_t s, logic tms);
        case (s)
            TLR:    return tms ? TLR    : RTI;
            RTI:    return tms ? SEL_DR : RTI;
            SEL_DR: return tms ? SEL_IR : CAP_DR;
            CAP_DR: return tms ? EX1_DR : SHF_DR;
            SHF_DR: return tms ? EX1_DR : SHF_DR;
            EX1_DR: return tms ? UPD_DR : PAU_DR;
            PAU_DR: return tms ? EX2_DR : PAU_DR;
            EX2_DR: return tms ? UPD_DR : SHF_DR;
            UPD_DR: return tms ? SEL_DR : RTI;
            SEL_IR: return tms ? TLR    : CAP_IR;
            CAP_IR: return tms ? EX1_IR : SHF_IR;
            SHF_IR: return tms ? EX1_IR : SHF_IR;
            EX1_IR: return tms ? UPD_IR : PAU_IR;
            PAU_IR: return tms ? EX2_IR : PAU_IR;
            EX2_IR: return tms ? UPD_IR : SHF_IR;
            default: return tms ? SEL_DR : RTI;
        endcase
    endfunction

    function automatic ir_dec_t ir_decode(logic [IR_W-1:0] op);
        ir_dec_t d;
        d.extest  = (op == OP_EXTEST);
        d.bsr_sel = (op == OP_EXTEST) || (op == OP_SAMPLE);
        return d;
    endfunction

endpackage

// File: rtl/bsf_tap_ctrl.sv
module bsf_tap_ctrl
    import bsf_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_t state
);
    always_ff @(posedge tck) begin
        if (rst) state <= TLR;
        else     state <= tap_next(state, tms);
    end
endmodule

// File: rtl/bsf_ir_reg.sv
module bsf_ir_reg
    import bsf_pkg::*;
(
    input  logic       tck,
    input  tap_state_t state,
    input  logic       tdi,
    output logic       sr_out,
    output ir_dec_t    dec
);
    logic [IR_W-1:0] sr;
    logic [IR_W-1:0] ir;

    always_ff @(posedge tck) begin
        if (state == CAP_IR)      sr <= IR_CAPTURE;
        else if (state == SHF_IR) sr <= {tdi, sr[IR_W-1:1]};
    end

    always_ff @(negedge tck) begin
        if (state == TLR)         ir <= OP_BYPASS;
        else if (state == UPD_IR) ir <= sr;
    end

    assign sr_out = sr[0];
    assign dec    = ir_decode(ir);
endmodule

// File: rtl/bsf_bsr.sv
module bsf_bsr
    import bsf_pkg::*;
#(
    parameter  int ADDR_W = 24,
    parameter  int DATA_W = 16,
    localparam int DR_W   = ADDR_W + DATA_W + 2
)(
    input  logic            tck,
    input  tap_state_t      state,
    input  logic            tdi,
    input  logic            sel,
    input  logic            force_we_hi,
    input  logic            hold_off,
    output logic            sr_out,
    output logic [DR_W-1:0] shadow
);
    localparam logic [DR_W-1:0] SAFE = {2'b11, {(DR_W-2){1'b0}}};

    logic [DR_W-1:0] sr;

    always_ff @(posedge tck) begin
        if (sel) begin
            if (state == CAP_DR)      sr <= shadow;
            else if (state == SHF_DR) sr <= {tdi, sr[DR_W-1:1]};
        end
    end

    always_ff @(negedge tck) begin
        if (state == TLR) begin
            shadow <= SAFE;
        end else if (state == UPD_DR && sel && !hold_off) begin
            shadow <= sr;
            if (force_we_hi) shadow[DR_W-1] <= 1'b1;
        end
    end

    assign sr_out = sr[0];
endmodule

// File: rtl/bsf_aw_pulse.sv
module bsf_aw_pulse
    import bsf_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int LOW_CYC   = 2,
    parameter int HOLD_CYC  = 1
)(
    input  logic tck,
    input  logic rst,
    input  logic req,
    output logic busy,
    output logic we_low,
    output logic overrun
);
    localparam int MAXC  = (SETUP_CYC > LOW_CYC) ?
                           ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                           ((LOW_CYC > HOLD_CYC) ? LOW_CYC : HOLD_CYC);
    localparam int CNT_W = $clog2(MAXC) + 1;

    aw_phase_t        phase;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge tck) begin
        if (rst) begin
            phase   <= AW_IDLE;
            cnt     <= '0;
            overrun <= 1'b0;
        end else begin
            if (req && phase != AW_IDLE) overrun <= 1'b1;
            case (phase)
                AW_IDLE: if (req) begin
                    phase <= AW_SETUP;
                    cnt   <= CNT_W'(SETUP_CYC - 1);
                end
                AW_SETUP: if (cnt == '0) begin
                    phase <= AW_LOW;
                    cnt   <= CNT_W'(LOW_CYC - 1);
                end else cnt <= cnt - 1'b1;
                AW_LOW: if (cnt == '0) begin
                    phase <= AW_HOLD;
                    cnt   <= CNT_W'(HOLD_CYC - 1);
                end else cnt <= cnt - 1'b1;
                AW_HOLD: if (cnt == '0) begin
                    phase <= AW_IDLE;
                end else cnt <= cnt - 1'b1;
                default: phase <= AW_IDLE;
            endcase
        end
    end

    assign busy   = (phase != AW_IDLE);
    assign we_low = (phase == AW_LOW);
endmodule

// File: rtl/bsf_write_seq.sv
module bsf_write_seq
    import bsf_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 16,
    parameter int SETUP_CYC = 1,
    parameter int LOW_CYC   = 2,
    parameter int HOLD_CYC  = 1
)(
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    input  logic              aw_en,
    output logic              tdo,
    output logic [ADDR_W-1:0] flash_addr,
    output logic [DATA_W-1:0] flash_data,
    output logic              flash_ce_n,
    output logic              flash_we_n,
    output logic              aw_overrun
);
    localparam int DR_W = ADDR_W + DATA_W + 2;

    logic            rst;
    tap_state_t      state;
    ir_dec_t         dec;
    logic            ir_out, bsr_out;
    logic            byp;
    logic [DR_W-1:0] shadow;
    logic            aw_req, aw_busy, aw_low;
    logic            ir_extest;

    assign rst       = ~trst_n;
    assign ir_extest = dec.extest;

    bsf_tap_ctrl u_tap (.tck(tck), .rst(rst), .tms(tms), .state(state));

    bsf_ir_reg u_ir (.tck(tck), .state(state), .tdi(tdi), .sr_out(ir_out), .dec(dec));

    bsf_bsr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bsr (
        .tck(tck), .state(state), .tdi(tdi), .sel(dec.bsr_sel),
        .force_we_hi(aw_en), .hold_off(aw_busy),
        .sr_out(bsr_out), .shadow(shadow)
    );

    assign aw_req = (state == UPD_DR) && aw_en && dec.extest;

    bsf_aw_pulse #(.SETUP_CYC(SETUP_CYC), .LOW_CYC(LOW_CYC), .HOLD_CYC(HOLD_CYC)) u_aw (
        .tck(tck), .rst(rst), .req(aw_req),
        .busy(aw_busy), .we_low(aw_low), .overrun(aw_overrun)
    );

    always_ff @(posedge tck) begin
        if (state == CAP_DR)      byp <= 1'b0;
        else if (state == SHF_DR) byp <= tdi;
    end

    always_ff @(negedge tck) begin
        if (state == SHF_IR)      tdo <= ir_out;
        else if (state == SHF_DR) tdo <= dec.bsr_sel ? bsr_out : byp;
        else                      tdo <= 1'b0;
    end

    always_comb begin
        if (dec.extest) begin
            flash_addr = shadow[ADDR_W-1:0];
            flash_data = shadow[ADDR_W+DATA_W-1:ADDR_W];
            flash_ce_n = shadow[DR_W-2];
            flash_we_n = shadow[DR_W-1] & ~aw_low;
        end else begin
            flash_addr = '0;
            flash_data = '0;
            flash_ce_n = 1'b1;
            flash_we_n = 1'b1;
        end
    end
endmodule

// File: rtl/bsf_write_seq_chk.sv
module bsf_write_seq_chk
    import bsf_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
)(
    input logic              tck,
    input logic              trst_n,
    input logic              tms,
    input logic              aw_en,
    input logic              tdo,
    input logic [ADDR_W-1:0] flash_addr,
    input logic [DATA_W-1:0] flash_data,
    input logic              flash_ce_n,
    input logic              flash_we_n,
    input logic              aw_overrun,
    input tap_state_t        tap_state,
    input logic              ir_extest
);
    assert_five_tms_reset_R1: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
        |-> tap_state == TLR);

    assert_safe_pins_R4: assert property (@(posedge tck) disable iff (!trst_n)
        !ir_extest |-> (flash_we_n && flash_ce_n && flash_addr == '0 && flash_data == '0));

    assert_pulse_low_R6: assert property (@(posedge tck) disable iff (!trst_n)
        (aw_en && $past(aw_en) && $fell(flash_we_n)) |=> !flash_we_n);

    assert_pulse_end_R6: assert property (@(posedge tck) disable iff (!trst_n)
        (aw_en && $past(aw_en) && $fell(flash_we_n)) |=> ##1 flash_we_n);

    assert_overrun_sticky_R7: assert property (@(posedge tck) disable iff (!trst_n)
        $past(aw_overrun) |-> aw_overrun);

    assert_tdo_quiet_R8: assert property (@(posedge tck) disable iff (!trst_n)
        !(tap_state == SHF_DR || tap_state == SHF_IR) |-> !tdo);

    assert_bus_stable_R9: assert property (@(posedge tck) disable iff (!trst_n)
        (aw_en && !flash_we_n) |-> ($stable(flash_addr) && $stable(flash_data)));
endmodule

bind bsf_write_seq bsf_write_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .tck(tck), .trst_n(trst_n), .tms(tms), .aw_en(aw_en), .tdo(tdo),
    .flash_addr(flash_addr), .flash_data(flash_data), .flash_ce_n(flash_ce_n),
    .flash_we_n(flash_we_n), .aw_overrun(aw_overrun),
    .tap_state(state), .ir_extest(ir_extest)
);

// File: tb/sim_bsf_write_seq.sv
module sim_bsf_write_seq;
    logic        tck = 1'b0;
    logic        trst_n = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic        aw_en = 1'b0;
    logic        tdo;
    logic [23:0] flash_addr;
    logic [15:0] flash_data;
    logic        flash_ce_n, flash_we_n, aw_overrun;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    logic        s_tdo, s_we, s_ce, s_ovr;
    logic [23:0] s_addr;
    logic [15:0] s_data;

    always #4 tck = ~tck;

    bsf_write_seq u0 (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .aw_en(aw_en),
        .tdo(tdo), .flash_addr(flash_addr), .flash_data(flash_data),
        .flash_ce_n(flash_ce_n), .flash_we_n(flash_we_n), .aw_overrun(aw_overrun)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // drive just after the falling edge, sample just before the rising edge
    task automatic tick(input logic m, input logic d);
        @(negedge tck);
        #1;
        tms = m;
        tdi = d;
        #2;
        s_tdo  = tdo;
        s_we   = flash_we_n;
        s_ce   = flash_ce_n;
        s_addr = flash_addr;
        s_data = flash_data;
        s_ovr  = aw_overrun;
        @(posedge tck);
    endtask

    task automatic reset_dut();
        trst_n = 1'b0;
        tms    = 1'b1;
        repeat (3) @(posedge tck);
        @(negedge tck);
        #1 trst_n = 1'b1;
        tick(0, 0);
    endtask

    task automatic shift_ir(input logic [3:0] op, output logic [3:0] cap);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 4; i++) begin
            tick(i == 3, op[i]);
            cap[i] = s_tdo;
        end
        tick(1, 0);
        tick(0, 0);
    endtask

    task automatic shift_dr(input logic [41:0] v, input int n, input bit to_rti,
                            output logic [41:0] cap);
        cap = '0;
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, v[i]);
            cap[i] = s_tdo;
        end
        tick(1, 0);
        if (to_rti) tick(0, 0);
    endtask

    task automatic t_reset();
        logic [3:0] c;
        reset_dut();
        chk("R4 reset we_n", s_we, 1);
        chk("R4 reset ce_n", s_ce, 1);
        chk("R4 reset addr", s_addr, 0);
        chk("R7 reset overrun", s_ovr, 0);
        chk("R8 reset tdo", s_tdo, 0);
        shift_ir(4'b1111, c);
        chk("R2 ir capture", c, 4'b0001);
    endtask

    task automatic t_bypass();
        logic [3:0]  c;
        logic [41:0] d;
        shift_ir(4'b1111, c);
        shift_dr(42'hB6, 8, 1, d);
        chk("R2 bypass delay", d[7:0], 8'h6C);
        shift_ir(4'b0101, c);
        shift_dr(42'h5A, 8, 1, d);
        chk("R2 unused code acts as bypass", d[7:0], 8'hB4);
    endtask

    task automatic t_plain();
        logic [3:0]  c;
        logic [41:0] d;
        aw_en = 1'b0;
        shift_ir(4'b0000, c);
        shift_dr({1'b1, 1'b0, 16'hA5C3, 24'h123456}, 42, 1, d);
        chk("R5 plain scan1 we_n", s_we, 1);
        chk("R3 plain ce_n", s_ce, 0);
        chk("R3 plain addr", s_addr, 24'h123456);
        chk("R3 plain data", s_data, 16'hA5C3);
        shift_dr({1'b0, 1'b0, 16'hA5C3, 24'h123456}, 42, 1, d);
        chk("R3 readback of latch", d, {1'b1, 1'b0, 16'hA5C3, 24'h123456});
        chk("R5 plain scan2 we_n", s_we, 0);
        shift_dr({1'b1, 1'b0, 16'hA5C3, 24'h123456}, 42, 1, d);
        chk("R5 plain scan3 we_n", s_we, 1);
    endtask

    task automatic t_sample();
        logic [3:0] c;
        shift_ir(4'b0001, c);
        chk("R4 sample pins addr", s_addr, 0);
        chk("R4 sample pins ce_n", s_ce, 1);
        shift_ir(4'b0000, c);
        chk("R4 extest restores addr", s_addr, 24'h123456);
        chk("R4 extest restores ce_n", s_ce, 0);
    endtask

    task automatic t_auto();
        logic [41:0] d;
        logic [4:0]  we_seen;
        aw_en = 1'b1;
        shift_dr({1'b0, 1'b0, 16'h1234, 24'h00ABCD}, 42, 1, d);
        chk("R6 latch we forced high", s_we, 1);
        for (int k = 0; k < 5; k++) begin
            tick(0, 0);
            we_seen[k] = s_we;
            chk("R9 addr during pulse", s_addr, 24'h00ABCD);
        end
        chk("R6 pulse shape", we_seen, 5'b11001);
        shift_dr({1'b0, 1'b0, 16'h0F0F, 24'h000777}, 42, 1, d);
        chk("R6 readback we bit", d[41], 1);
        chk("R3 readback addr", d[23:0], 24'h00ABCD);
        repeat (6) tick(0, 0);
    endtask

    task automatic t_overrun();
        logic [41:0] d;
        logic [8:0]  seq;
        logic [8:0]  we_seen, ovr_seen;
        seq = 9'b001011101; // bit k is tms for tick k
        shift_dr({1'b0, 1'b0, 16'h5A5A, 24'h0000EE}, 42, 0, d);
        for (int k = 0; k < 9; k++) begin
            tick(seq[k], 0);
            we_seen[k]  = s_we;
            ovr_seen[k] = s_ovr;
            chk("R7 latch kept", s_addr, 24'h0000EE);
        end
        chk("R7 no second pulse", we_seen, 9'b111110011);
        chk("R7 overrun flag", ovr_seen, 9'b111100000);
        tick(1, 0); tick(1, 0); tick(0, 0);
        repeat (6) tick(0, 0);
        chk("R7 overrun sticky", s_ovr, 1);
    endtask

    task automatic t_tlr();
        logic [41:0] d;
        logic [3:0]  c;
        repeat (5) tick(1, 0);
        tick(0, 0);
        chk("R1 tms reset pins we_n", s_we, 1);
        chk("R1 tms reset pins addr", s_addr, 0);
        shift_dr(42'hF, 4, 1, d);
        chk("R1 tms reset selects bypass", d[3:0], 4'b1110);
        shift_ir(4'b0000, c);
        chk("R1 ir capture after reset", c, 4'b0001);
        chk("R1 latch reset to safe ce_n", s_ce, 1);
    endtask

    task automatic t_trst();
        reset_dut();
        chk("R7 trst clears overrun", s_ovr, 0);
        chk("R1 trst pins we_n", s_we, 1);
    endtask

    task automatic t_tdo();
        logic [3:0]  c;
        logic [41:0] d;
        shift_ir(4'b1111, c);
        shift_dr(42'hFF, 8, 1, d);
        tick(0, 1);
        chk("R8 tdo quiet in idle", s_tdo, 0);
        tick(1, 1);
        tick(0, 1);
        tick(0, 1);
        chk("R8 tdo quiet in capture", s_tdo, 0);
        tick(1, 0); tick(1, 0); tick(0, 0);
    endtask

    initial begin
        t_reset();
        t_bypass();
        t_plain();
        t_sample();
        t_auto();
        t_overrun();
        t_tlr();
        t_trst();
        t_tdo();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge tck);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule